// File: doc/BRIEF.md
# Configuration Access Trap Unit

This block sits beside a simplified access bus that carries configuration accesses to two configuration functions and plain I/O accesses. For every access it decides whether the access is allowed to reach its target and whether an I/O access must be completed as a delayed transaction. It raises a system-management interrupt (SMI) pulse whenever an enabled configuration trap fires.

The trap policy depends on the function. For function 1, an enabled trap blocks writes and lets reads through. For function 0, an enabled trap only observes the access, and both reads and writes complete. A small set of fixed legacy I/O windows can each be flagged for delayed completion through its own enable bit. These windows are the two disk-channel blocks, the two interrupt-controller port pairs and the timer ports.

The trap enables, the delayed-completion enables and a two-level sticky SMI status live in function 0 configuration space. Software reads them there and clears the status by writing 1 to it.

Top module: `cfg_trap_unit`

## Requirements
- R1: When trap-control bit 0 (function 1 trap) is 1, a valid configuration access with function 1 makes `smi_o` high for exactly the one cycle after the access cycle.
- R2: A function 1 configuration write that is trapped has `pass_o` = 0 in its access cycle. A trapped function 1 read has `pass_o` = 1.
- R3: When trap-control bit 1 (function 0 trap) is 1, a valid function 0 configuration access raises the SMI pulse of R1, and `pass_o` stays 1 for both reads and writes.
- R4: Each trapped access sets bit 0 of the top status register (offset 42h) and bit 0 of the detail status register (offset 43h). Both bits stay set until a function 0 write of a 1 to that bit. Writing 0 leaves them unchanged.
- R5: An I/O access in 170h–177h has `delay_o` = 1 only when delay-control bit 0 is 1. An I/O access in 1F0h–1F7h has `delay_o` = 1 only when delay-control bit 1 is 1. Both bits reset to 0.
- R6: I/O ports 20h–21h and A0h–A1h are delayed when delay-control bit 2 is 1 (reset 0). Ports 40h–43h are delayed when delay-control bit 3 is 1 (reset 1).
- R7: Trap-control (offset 40h) bit 2 always reads 1 and bits 7:3 always read 0. Delay-control (offset 41h) bits 7:4 always read 0. Written values do not change this.
- R8: An access that matches no enabled trap or delayed window gives `smi_o` = 0 on the next cycle, `pass_o` = 1 and `delay_o` = 0. Configuration accesses never assert `delay_o`, and I/O accesses never raise an SMI.
- R9: After reset, offsets 40h, 41h, 42h and 43h read 04h, 08h, 00h and 00h, and `smi_o` is 0.
- R10: If a trap event and a write-1-to-clear of a status bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is present this cycle |
| acc_io_i | input | 1 | 1 for an I/O access, 0 for a configuration access |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_func_i | input | 1 | Configuration function number (0 or 1) |
| acc_addr_i | input | ADDR_W | I/O port address, or configuration register offset in the low OFS_W bits |
| acc_wdata_i | input | DATA_W | Write data |
| pass_o | output | 1 | Access may reach its target this cycle |
| delay_o | output | 1 | I/O access is to be completed as a delayed transaction |
| smi_o | output | 1 | SMI pulse, one cycle after a trapped access |
| rdata_o | output | DATA_W | Read data for function 0 configuration reads of this block's registers, else 0 |

## Verification
The assertions assume that each access is presented for a single cycle with `acc_valid_i` high and stable control fields. They also assume that reset holds `acc_valid_i` low, so that checks looking one cycle back never see a stale access. The bench drives every access for exactly one clock, from a falling edge to the next falling edge. It leaves an idle cycle between accesses and keeps `acc_valid_i` low throughout reset. Under these conditions a pulse on `smi_o` can always be traced to one configuration access. Status clears can be tested both alone and in the same cycle as a trap.

// File: rtl/cfg_trap_pkg.sv
package cfg_trap_pkg;

   localparam int NUM_WIN  = 5;
   localparam int NUM_DLY  = 4;

   localparam int TRAP_F1_BIT = 0;
   localparam int TRAP_F0_BIT = 1;
   localparam int TRAP_FIX1_BIT = 2;

   function automatic logic [15:0] win_lo(input int idx);
      case (idx)
         0:       return 16'h0170;
         1:       return 16'h01F0;
         2:       return 16'h0020;
         3:       return 16'h00A0;
         default: return 16'h0040;
      endcase
   endfunction

   function automatic logic [15:0] win_hi(input int idx);
      case (idx)
         0:       return 16'h0177;
         1:       return 16'h01F7;
         2:       return 16'h0021;
         3:       return 16'h00A1;
         default: return 16'h0043;
      endcase
   endfunction

   function automatic int win_enable(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         3:       return 2;
         default: return 3;
      endcase
   endfunction

endpackage

// File: rtl/cfg_trap_io_decode.sv
module cfg_trap_io_decode
   import cfg_trap_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_DLY-1:0] dly_en_i,
   output logic               hit_o
);

   logic [NUM_WIN-1:0] win_hit;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(win_lo(w));
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(win_hi(w));
      localparam int                EN = win_enable(w);
      assign win_hit[w] = (addr_i >= LO) && (addr_i <= HI) && dly_en_i[EN];
   end

   assign hit_o = |win_hit;

endmodule

// File: rtl/cfg_trap_regs.sv
module cfg_trap_regs
   import cfg_trap_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               OFS_W     = 8,
   parameter int               OFS_TRAP  = 'h40,
   parameter int               OFS_DLY   = 'h41,
   parameter int               OFS_TOP   = 'h42,
   parameter int               OFS_SUB   = 'h43,
   parameter logic [NUM_DLY-1:0] DLY_RST = 4'b1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [OFS_W-1:0]   ofs_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               trap_evt_i,
   output logic               en_f1_o,
   output logic               en_f0_o,
   output logic [NUM_DLY-1:0] dly_en_o,
   output logic [DATA_W-1:0]  rdata_o
);

   localparam logic [OFS_W-1:0] A_TRAP = OFS_W'(OFS_TRAP);
   localparam logic [OFS_W-1:0] A_DLY  = OFS_W'(OFS_DLY);
   localparam logic [OFS_W-1:0] A_TOP  = OFS_W'(OFS_TOP);
   localparam logic [OFS_W-1:0] A_SUB  = OFS_W'(OFS_SUB);

   logic [1:0]         trap_q;
   logic [NUM_DLY-1:0] dly_q;
   logic               top_q, sub_q;
   logic               clr_top, clr_sub;

   assign clr_top = wr_en_i && (ofs_i == A_TOP) && wdata_i[0];
   assign clr_sub = wr_en_i && (ofs_i == A_SUB) && wdata_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_q <= '0;
         dly_q  <= DLY_RST;
         top_q  <= 1'b0;
         sub_q  <= 1'b0;
      end else begin
         if (wr_en_i && ofs_i == A_TRAP) trap_q <= wdata_i[1:0];
         if (wr_en_i && ofs_i == A_DLY)  dly_q  <= wdata_i[NUM_DLY-1:0];
         // trap event has priority over a clear in the same cycle (R10)
         if (trap_evt_i)    top_q <= 1'b1;
         else if (clr_top)  top_q <= 1'b0;
         if (trap_evt_i)    sub_q <= 1'b1;
         else if (clr_sub)  sub_q <= 1'b0;
      end
   end

   assign en_f1_o  = trap_q[TRAP_F1_BIT];
   assign en_f0_o  = trap_q[TRAP_F0_BIT];
   assign dly_en_o = dly_q;

   always_comb begin
      rdata_o = '0;
      if (ofs_i == A_TRAP) begin
         rdata_o[1:0]           = trap_q;
         rdata_o[TRAP_FIX1_BIT] = 1'b1;
      end else if (ofs_i == A_DLY) begin
         rdata_o[NUM_DLY-1:0] = dly_q;
      end else if (ofs_i == A_TOP) begin
         rdata_o[0] = top_q;
      end else if (ofs_i == A_SUB) begin
         rdata_o[0] = sub_q;
      end
   end

   p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_evt_i |=> (top_q && sub_q));

   p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (top_q && !clr_top) |=> top_q);

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_evt_i && clr_sub) |=> sub_q);

endmodule

// File: rtl/cfg_trap_unit.sv
module cfg_trap_unit
   import cfg_trap_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int OFS_W    = 8,
   parameter int OFS_TRAP = 'h40,
   parameter int OFS_DLY  = 'h41,
   parameter int OFS_TOP  = 'h42,
   parameter int OFS_SUB  = 'h43
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid_i,
   input  logic              acc_io_i,
   input  logic              acc_write_i,
   input  logic              acc_func_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [DATA_W-1:0] acc_wdata_i,
   output logic              pass_o,
   output logic              delay_o,
   output logic              smi_o,
   output logic [DATA_W-1:0] rdata_o
);

   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must cover the 1F7h window");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (OFS_W > ADDR_W) begin : g_bad_ofs
      $error("OFS_W must not exceed ADDR_W");
   end

   logic               cfg_acc, f1_acc, f0_acc, trap_evt, io_hit;
   logic               en_f1, en_f0;
   logic [NUM_DLY-1:0] dly_en;
   logic [DATA_W-1:0]  reg_rdata;
   logic               smi_q;

   assign cfg_acc  = acc_valid_i && !acc_io_i;
   assign f1_acc   = cfg_acc && acc_func_i;
   assign f0_acc   = cfg_acc && !acc_func_i;
   assign trap_evt = (f1_acc && en_f1) || (f0_acc && en_f0);

   cfg_trap_regs #(
      .DATA_W (DATA_W), .OFS_W (OFS_W),
      .OFS_TRAP (OFS_TRAP), .OFS_DLY (OFS_DLY),
      .OFS_TOP (OFS_TOP), .OFS_SUB (OFS_SUB),
      .DLY_RST (4'b1000)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (f0_acc && acc_write_i),
      .ofs_i      (acc_addr_i[OFS_W-1:0]),
      .wdata_i    (acc_wdata_i),
      .trap_evt_i (trap_evt),
      .en_f1_o    (en_f1),
      .en_f0_o    (en_f0),
      .dly_en_o   (dly_en),
      .rdata_o    (reg_rdata)
   );

   cfg_trap_io_decode #(.ADDR_W (ADDR_W)) u_dec (
      .addr_i   (acc_addr_i),
      .dly_en_i (dly_en),
      .hit_o    (io_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_q <= 1'b0;
      else        smi_q <= trap_evt;
   end

   assign smi_o   = smi_q;
   assign pass_o  = !(f1_acc && en_f1 && acc_write_i);
   assign delay_o = acc_valid_i && acc_io_i && io_hit;
   assign rdata_o = (f0_acc && !acc_write_i) ? reg_rdata : '0;

   p_smi_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> $past(acc_valid_i && !acc_io_i));

   p_block_traps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_o |=> smi_o);

   p_f0_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !acc_io_i && !acc_func_i) |-> pass_o);

   p_io_no_smi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && acc_io_i) |=> !smi_o);

   p_cfg_no_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid_i && acc_io_i) |-> !delay_o);

endmodule

// File: tb/cfg_trap_unit_tb.sv
module cfg_trap_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid_i = 1'b0, acc_io_i = 1'b0, acc_write_i = 1'b0, acc_func_i = 1'b0;
   logic [15:0] acc_addr_i = '0;
   logic [7:0]  acc_wdata_i = '0;
   logic        pass_o, delay_o, smi_o;
   logic [7:0]  rdata_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_trap_unit u_dut (
      .clk (clk), .rst_n (rst_n),
      .acc_valid_i (acc_valid_i), .acc_io_i (acc_io_i),
      .acc_write_i (acc_write_i), .acc_func_i (acc_func_i),
      .acc_addr_i (acc_addr_i), .acc_wdata_i (acc_wdata_i),
      .pass_o (pass_o), .delay_o (delay_o), .smi_o (smi_o), .rdata_o (rdata_o)
   );

   // fields: io, write, func, addr[15:0], wdata[7:0], exp pass, exp delay, exp smi
   localparam logic [29:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 1'b0, 16'h0170, 8'h00, 3'b110},
      {1'b1, 1'b1, 1'b0, 16'h0177, 8'h5A, 3'b110},
      {1'b1, 1'b0, 1'b0, 16'h0178, 8'h00, 3'b100},
      {1'b1, 1'b1, 1'b0, 16'h01F3, 8'h11, 3'b110},
      {1'b1, 1'b0, 1'b0, 16'h0021, 8'h00, 3'b110},
      {1'b1, 1'b0, 1'b0, 16'h00A0, 8'h00, 3'b110},
      {1'b1, 1'b0, 1'b0, 16'h0022, 8'h00, 3'b100},
      {1'b1, 1'b1, 1'b0, 16'h0043, 8'h36, 3'b110},
      {1'b1, 1'b0, 1'b0, 16'h0044, 8'h00, 3'b100},
      {1'b0, 1'b1, 1'b1, 16'h0010, 8'hAA, 3'b001},
      {1'b0, 1'b0, 1'b1, 16'h0010, 8'h00, 3'b101},
      {1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 3'b101},
      {1'b0, 1'b1, 1'b0, 16'h0050, 8'h77, 3'b101},
      {1'b1, 1'b0, 1'b0, 16'h016F, 8'h00, 3'b100}
   };

   logic       s_pass, s_delay, s_smi;
   logic [7:0] s_rdata;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic io, input logic wr, input logic fn,
                         input logic [15:0] addr, input logic [7:0] wd);
      @(negedge clk);
      acc_valid_i = 1'b1; acc_io_i = io; acc_write_i = wr; acc_func_i = fn;
      acc_addr_i = addr; acc_wdata_i = wd;
      #1;
      s_pass = pass_o; s_delay = delay_o; s_rdata = rdata_o;
      @(posedge clk);
      #1;
      s_smi = smi_o;
      @(negedge clk);
      acc_valid_i = 1'b0; acc_write_i = 1'b0;
   endtask

   task automatic cfg_wr(input logic [7:0] ofs, input logic [7:0] wd);
      access(1'b0, 1'b1, 1'b0, {8'h00, ofs}, wd);
   endtask

   task automatic cfg_rd(input logic [7:0] ofs);
      access(1'b0, 1'b0, 1'b0, {8'h00, ofs}, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 reset values
      check("R9 smi after reset", 32'(smi_o), 32'h0);
      cfg_rd(8'h40); check("R9 trap ctrl reset", 32'(s_rdata), 32'h04);
      check("R9 no smi on untrapped read", 32'(s_smi), 32'h0);
      cfg_rd(8'h41); check("R9 delay ctrl reset", 32'(s_rdata), 32'h08);
      cfg_rd(8'h42); check("R9 top status reset", 32'(s_rdata), 32'h00);
      cfg_rd(8'h43); check("R9 detail status reset", 32'(s_rdata), 32'h00);

      // R5 / R6 default enables
      access(1'b1, 1'b0, 1'b0, 16'h0170, 8'h00); check("R5 secondary window off by default", 32'(s_delay), 32'h0);
      access(1'b1, 1'b0, 1'b0, 16'h01F0, 8'h00); check("R5 primary window off by default", 32'(s_delay), 32'h0);
      access(1'b1, 1'b0, 1'b0, 16'h0020, 8'h00); check("R6 interrupt ctrl off by default", 32'(s_delay), 32'h0);
      access(1'b1, 1'b0, 1'b0, 16'h0040, 8'h00); check("R6 timer on by default", 32'(s_delay), 32'h1);

      // R8 untrapped function 1 write
      access(1'b0, 1'b1, 1'b1, 16'h0010, 8'h55);
      check("R8 untrapped f1 write passes", 32'(s_pass), 32'h1);
      check("R8 untrapped f1 write no smi", 32'(s_smi), 32'h0);

      // R7 reserved bits
      cfg_wr(8'h40, 8'hF8); cfg_rd(8'h40); check("R7 trap ctrl fixed bits", 32'(s_rdata), 32'h04);
      cfg_wr(8'h41, 8'hF0); cfg_rd(8'h41); check("R7 delay ctrl fixed bits", 32'(s_rdata), 32'h00);

      // configure for the vector table
      cfg_wr(8'h40, 8'h03);
      cfg_wr(8'h41, 8'h0F);
      check("R3 f0 write while trapped raises smi", 32'(s_smi), 32'h1);
      check("R3 f0 write while trapped passes", 32'(s_pass), 32'h1);

      for (int i = 0; i < NVEC; i++) begin
         access(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26:11], VEC[i][10:3]);
         check($sformatf("R2 R5 R6 R8 vec%0d pass", i), 32'(s_pass), 32'(VEC[i][2]));
         check($sformatf("R5 R6 R8 vec%0d delay", i), 32'(s_delay), 32'(VEC[i][1]));
         check($sformatf("R1 R3 R8 vec%0d smi", i), 32'(s_smi), 32'(VEC[i][0]));
      end

      // R4 sticky status and write-1-to-clear
      cfg_rd(8'h42); check("R4 top status set", 32'(s_rdata), 32'h01);
      cfg_rd(8'h43); check("R4 detail status set", 32'(s_rdata), 32'h01);
      cfg_wr(8'h40, 8'h00);
      cfg_wr(8'h42, 8'h00); cfg_rd(8'h42); check("R4 write 0 keeps top", 32'(s_rdata), 32'h01);
      cfg_wr(8'h42, 8'h01); cfg_rd(8'h42); check("R4 top cleared", 32'(s_rdata), 32'h00);
      cfg_rd(8'h43); check("R4 detail unaffected by top clear", 32'(s_rdata), 32'h01);
      cfg_wr(8'h43, 8'h01); cfg_rd(8'h43); check("R4 detail cleared", 32'(s_rdata), 32'h00);

      // R10 trap and clear in the same cycle
      cfg_wr(8'h40, 8'h02);
      cfg_rd(8'h42); check("R10 no stray status", 32'(s_rdata), 32'h00);
      cfg_wr(8'h42, 8'h01);
      check("R10 clearing write is itself trapped", 32'(s_smi), 32'h1);
      cfg_rd(8'h42); check("R10 set wins over clear", 32'(s_rdata), 32'h01);

      // R1 single-cycle pulse, function 1 trap only
      cfg_wr(8'h40, 8'h00);
      access(1'b0, 1'b0, 1'b1, 16'h0008, 8'h00); check("R8 f1 read with trap off", 32'(s_smi), 32'h0);
      cfg_wr(8'h40, 8'h01);
      check("R3 f0 access with f0 trap off has no smi", 32'(s_smi), 32'h0);
      access(1'b0, 1'b0, 1'b1, 16'h0008, 8'h00);
      check("R1 f1 read trapped smi", 32'(s_smi), 32'h1);
      check("R2 trapped f1 read passes", 32'(s_pass), 32'h1);
      @(posedge clk); #1;
      check("R1 smi lasts one cycle", 32'(smi_o), 32'h0);

      finish_run();
   end

endmodule